// File: doc/BRIEF.md
# Time-Multiplexed Multi-Rate Scanner

This block recovers eight independent rate clocks from one shared rate multiplexer by sweeping its select lines. A free-running scan counter drives the low select bits. A parameter holds the top select bit at a fixed level, so the multiplexer visits the eight rate sources of one bank in turn. The multiplexer output `z` is registered.

An addressed latch takes the scan address, delayed by the same one clock, and writes `z` into the matching bit. Each bit of `rate_out` therefore follows its own source. It is refreshed once every scan period and holds its level between visits.

The rate sources come from an external divider network and enter as plain levels. There is no data stream here, so every pin is a plain control or clock-level signal without a handshake. A write enable becomes active only once the first valid `z` has been registered after reset.

Top module: `mrs_scanner`

## Requirements
- R1: After reset `scan_q` is 0. It advances by one on every clock and wraps from 7 back to 0 (SCAN_W=3).
- R2: One clock after the counter holds value k, `z` equals the level that `rate_in[8+k]` had before that edge. The select is {1, k}, so the default bank takes input indices 8 to 15.
- R3: Inputs `rate_in[0]` to `rate_in[7]` (the unselected bank) have no effect on `z` or `rate_out`.
- R4: Bit k of `rate_out` takes the value `z` had while the delayed address was k. That value is the `rate_in[8+k]` level sampled at the edge where `scan_q` was k. It becomes visible after the edge that follows that sampling edge.
- R5: On every clock, all `rate_out` bits other than the one addressed by the delayed scan address keep their value.
- R6: While `rst_n` is low (asynchronous, active low), `scan_q`, `z` and `rate_out` are all 0, whatever the rate inputs do.
- R7: Take a source that holds each level for at least one scan period (8 clocks), or a static source (zero rate). Its output bit differs from it for no more than 10 clocks after the source changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal scan clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| rate_in | input | 16 | Rate source levels, indexed by select code |
| scan_q | output | 3 | Scan counter value (low select bits) |
| z | output | 1 | Registered multiplexer output |
| rate_out | output | 8 | Parallel recovered rate outputs |

## Verification
The bench uses the defaults SCAN_W=3 and BANK=1, which gives sixteen rate inputs and eight channels. This is small enough that every channel's output can be predicted on every clock from a stored history of the inputs.

The selected-bank sources have half periods of 3, 5, 8, 13, 16 and 24 clocks, plus one source tied high and one tied low. This covers sources faster than, equal to and slower than the scan period, as well as zero-rate levels. The unselected bank carries pseudo-random noise throughout.

A reset is applied in the middle of the run, and a second run starts at a shifted phase. Together these place source edges at every scan position.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  // Default scan width: 2**SCAN_W channels, 2**(SCAN_W+1) multiplexer inputs.
  localparam int unsigned SCAN_W_DFLT = 3;
  // Default bank: top select bit held high.
  localparam int unsigned BANK_DFLT   = 1;

  function automatic int unsigned chan_count(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/mrs_scan_counter.sv
module mrs_scan_counter #(
  parameter int unsigned SCAN_W = mrs_pkg::SCAN_W_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SCAN_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + SCAN_W'(1);
  end
endmodule

// File: rtl/mrs_rate_mux.sv
module mrs_rate_mux #(
  parameter int unsigned SCAN_W = mrs_pkg::SCAN_W_DFLT,
  parameter int unsigned BANK   = mrs_pkg::BANK_DFLT,
  localparam int unsigned SEL_W = SCAN_W + 1,
  localparam int unsigned SRC_N = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  rate_in,
  input  logic [SCAN_W-1:0] sel_lo,
  output logic              z,
  output logic [SCAN_W-1:0] z_addr,
  output logic              z_vld
);
  logic [SEL_W-1:0] sel;
  assign sel = {1'(BANK), sel_lo};

  // z, its channel address and its validity advance together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z      <= 1'b0;
      z_addr <= '0;
      z_vld  <= 1'b0;
    end else begin
      z      <= rate_in[sel];
      z_addr <= sel_lo;
      z_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/mrs_addr_latch.sv
module mrs_addr_latch #(
  parameter int unsigned SCAN_W = mrs_pkg::SCAN_W_DFLT,
  localparam int unsigned CHAN_N = 1 << SCAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SCAN_W-1:0] addr,
  input  logic              din,
  output logic [CHAN_N-1:0] q
);
  for (genvar g = 0; g < CHAN_N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q[g] <= 1'b0;
      else if (wr_en && addr == SCAN_W'(g))   q[g] <= din;
    end
  end
endmodule

// File: rtl/mrs_scanner.sv
module mrs_scanner #(
  parameter int unsigned SCAN_W = mrs_pkg::SCAN_W_DFLT,
  parameter int unsigned BANK   = mrs_pkg::BANK_DFLT,
  localparam int unsigned CHAN_N = mrs_pkg::chan_count(SCAN_W),
  localparam int unsigned SRC_N  = 1 << (SCAN_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  rate_in,
  output logic [SCAN_W-1:0] scan_q,
  output logic              z,
  output logic [CHAN_N-1:0] rate_out
);
  logic [SCAN_W-1:0] z_addr;
  logic              z_vld;

  mrs_scan_counter #(.SCAN_W(SCAN_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .cnt(scan_q)
  );

  mrs_rate_mux #(.SCAN_W(SCAN_W), .BANK(BANK)) mux_i (
    .clk(clk), .rst_n(rst_n), .rate_in(rate_in), .sel_lo(scan_q),
    .z(z), .z_addr(z_addr), .z_vld(z_vld)
  );

  mrs_addr_latch #(.SCAN_W(SCAN_W)) lat_i (
    .clk(clk), .rst_n(rst_n), .wr_en(z_vld), .addr(z_addr),
    .din(z), .q(rate_out)
  );
endmodule

// File: rtl/mrs_scanner_chk.sv
module mrs_scanner_chk #(
  parameter int unsigned SCAN_W = mrs_pkg::SCAN_W_DFLT,
  parameter int unsigned BANK   = mrs_pkg::BANK_DFLT,
  localparam int unsigned CHAN_N = 1 << SCAN_W,
  localparam int unsigned SRC_N  = 1 << (SCAN_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  rate_in,
  input logic [SCAN_W-1:0] scan_q,
  input logic              z,
  input logic [CHAN_N-1:0] rate_out
);
  logic [1:0] age;
  logic       prev_low;
  logic       warm;
  logic       sel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm    = (age >= 2'd2);
  assign sel_now = rate_in[{1'(BANK), scan_q}];

  a_r1_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> scan_q == $past(scan_q) + SCAN_W'(1));

  a_r2_z_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> z == $past(sel_now));

  a_r4_latch_takes_z: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> rate_out[$past(scan_q, 2)] == $past(z));

  a_r5_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ((rate_out ^ $past(rate_out)) & ~(CHAN_N'(1) << $past(scan_q, 2))) == '0);

  always_ff @(posedge clk) begin
    prev_low <= !rst_n;
    if (prev_low && !rst_n) begin
      a_r6_reset_clear: assert (scan_q == '0 && z == 1'b0 && rate_out == '0)
        else $error("reset state not clear");
    end
  end
endmodule

bind mrs_scanner mrs_scanner_chk #(.SCAN_W(SCAN_W), .BANK(BANK)) chk_i (.*);

// File: tb/mrs_scanner_tb_top.sv
module mrs_scanner_tb_top;
  localparam int SW  = 3;
  localparam int CH  = 8;
  localparam int SRC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SRC-1:0] rate_in = '0;
  logic [SW-1:0] scan_q;
  logic          z;
  logic [CH-1:0] rate_out;

  always #4 clk = ~clk;

  mrs_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .rate_in(rate_in),
    .scan_q(scan_q), .z(z), .rate_out(rate_out)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int gcyc = 0;
  logic [SRC-1:0] hist [0:2047];
  int hp [CH] = '{3, 5, 8, 13, 16, 24, 0, 0};
  int lastchg [CH];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic src_val(input int k, input int c);
    if (hp[k] == 0) return (k == 6);
    return ((c / hp[k]) % 2) == 1;
  endfunction

  task automatic drive_next(input int phase);
    for (int k = 0; k < CH; k++) rate_in[8 + k] = src_val(k, gcyc + phase);
    rate_in[7:0] = lfsr[7:0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gcyc++;
  endtask

  task automatic check_reset(input string tag);
    chk({tag, " R6 scan_q"}, 32'(scan_q), 0);
    chk({tag, " R6 z"}, 32'(z), 0);
    chk({tag, " R6 rate_out"}, 32'(rate_out), 0);
  endtask

  task automatic run_segment(input int ncyc, input int phase);
    for (int e = 0; e < ncyc; e++) begin
      chk("R1 scan count", 32'(scan_q), 32'(e % 8));
      if (e >= 1) begin
        int n = e - 1;
        chk("R2/R3 registered z", 32'(z), 32'(hist[n][8 + (n % 8)]));
      end
      for (int k = 0; k < CH; k++) begin
        logic exp;
        if (e - 2 >= k) begin
          int n = (e - 2) - (((e - 2) - k) % 8);
          exp = hist[n][8 + k];
        end else exp = 1'b0;
        chk("R4/R5 latched channel", 32'(rate_out[k]), 32'(exp));
        if (k >= 2 && e >= 12) begin
          logic ok = (rate_out[k] == hist[e - 1][8 + k]) || (e - lastchg[k] <= 10);
          chk("R7 skew bound", 32'(ok), 1);
        end
      end
      drive_next(phase);
      hist[e] = rate_in;
      for (int k = 0; k < CH; k++)
        if (e == 0 || hist[e][8 + k] != hist[e - 1][8 + k]) lastchg[k] = e;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive_next(0);
      check_reset("initial");
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_segment(600, 0);
    rst_n = 1'b0;
    drive_next(0);
    @(negedge clk);
    check_reset("mid-run");
    drive_next(0);
    @(negedge clk);
    check_reset("mid-run held");
    rst_n = 1'b1;
    run_segment(400, 37);
    done = 1;
    finish_run();
  end
endmodule